// File: doc/BRIEF.md
# Condition Bit to Boolean Setter

This block turns one bit of a condition register into a value that can be written to a general register. The condition register is split into eight 4-bit fields. A 5-bit index picks the field with its upper three bits and the bit inside that field with its lower two bits. The selected bit can be tested for set or for clear. The outcome is then given either as 0/1 or as 0/all-ones.

A request is a one-cycle pulse on `req_i` that carries the operand and the controls. One cycle later the block presents the result with a one-cycle write strobe. The operation exists only while the feature-enable input is high. A request made while the feature is disabled produces a one-cycle illegal pulse and no write.

Top module: `cr_bool_set`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `result_o`, `wr_en_o` and `illegal_o` are all zero until the first request.
- R2: Index `bit_idx_i` selects condition bit `cr_i[31 - bit_idx_i]`. Field `bit_idx_i[4:2]` is a nibble, with field 0 in `cr_i[31:28]`. Inside the field, the bit under mask `4'b1000 >> bit_idx_i[1:0]` is used, so low index 0 is the field's most significant bit.
- R3: With `rev_i=0` and `neg_i=0`, the result is 1 when the selected bit is set and 0 when it is clear.
- R4: With `rev_i=1`, the test is inverted: the 0/1 outcome is 1 when the selected bit is clear.
- R5: With `neg_i=1`, the 0/1 outcome is negated in two's complement, so the result is 0 or `64'hFFFF_FFFF_FFFF_FFFF`.
- R6: A request accepted with `feat_en_i=1` raises `wr_en_o` for exactly the next cycle, with `result_o` valid in that cycle. Back-to-back requests give back-to-back strobes.
- R7: A request with `feat_en_i=0` raises `illegal_o` for exactly the next cycle. In that cycle `wr_en_o` stays low and `result_o` is zero. `wr_en_o` and `illegal_o` are never high together.
- R8: In a cycle that follows no request, `wr_en_o` and `illegal_o` are low and `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request strobe |
| cr_i | input | 32 | Condition register, eight 4-bit fields |
| bit_idx_i | input | 5 | Condition bit index |
| neg_i | input | 1 | Produce 0/all-ones instead of 0/1 |
| rev_i | input | 1 | Test the bit for clear instead of set |
| feat_en_i | input | 1 | Feature enable; low makes requests illegal |
| result_o | output | 64 | Registered boolean result |
| wr_en_o | output | 1 | One-cycle write strobe for result_o |
| illegal_o | output | 1 | One-cycle illegal-request strobe |

## Verification
The bench drives single set bits at the two ends of the register and inside middle fields, alongside all-zero and all-ones registers, under each combination of reverse and negate.

Each of these patterns targets a specific fault:
- A selector that takes field 0 from the low nibble, or counts in-field bits from the least significant end, returns the neighbouring or mirrored bit.
- Swapped reverse polarity flips the 0/1 outcome.
- A negate that only sets bit 0, or sign-extends the wrong way, gives 1 where all-ones is expected.

The disabled-feature request, the idle cycle after a write, and back-to-back requests catch these faults:
- a write that leaks through when the feature is off;
- a non-zero result during an illegal pulse;
- a result that clears or changes when nothing was requested;
- a strobe that lasts too long or is lost between adjacent requests.

// File: rtl/cr_bool_pkg.sv
package cr_bool_pkg;
  typedef struct packed {
    logic neg;
    logic rev;
  } bool_ctl_t;
endpackage

// File: rtl/cr_bit_pick.sv
module cr_bit_pick #(
  parameter int unsigned FIELDS  = 8,
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned CR_W   = FIELDS * FIELD_W,
  localparam int unsigned IDX_W  = $clog2(CR_W),
  localparam int unsigned LOW_W  = $clog2(FIELD_W)
) (
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  logic [FIELD_W-1:0] field_q [FIELDS];
  logic [FIELD_W-1:0] sel_field;
  logic [FIELD_W-1:0] mask;

  // field 0 sits in the top nibble
  for (genvar g = 0; g < FIELDS; g++) begin : g_unpack
    assign field_q[g] = cr_i[CR_W-1-g*FIELD_W -: FIELD_W];
  end

  always_comb begin
    sel_field = field_q[idx_i[IDX_W-1:LOW_W]];
    mask      = {1'b1, {(FIELD_W-1){1'b0}}} >> idx_i[LOW_W-1:0];
    bit_o     = |(sel_field & mask);
  end
endmodule

// File: rtl/cr_bool_form.sv
module cr_bool_form
  import cr_bool_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            bit_i,
  input  bool_ctl_t       ctl_i,
  output logic [XLEN-1:0] value_o
);
  logic            truth;
  logic [XLEN-1:0] one_hot;

  always_comb begin
    truth   = bit_i ^ ctl_i.rev;
    one_hot = {{(XLEN-1){1'b0}}, truth};
    value_o = ctl_i.neg ? (~one_hot + 1'b1) : one_hot;
  end
endmodule

// File: rtl/cr_bool_set.sv
module cr_bool_set
  import cr_bool_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned FIELDS  = 8,
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned CR_W   = FIELDS * FIELD_W,
  localparam int unsigned IDX_W  = $clog2(CR_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             neg_i,
  input  logic             rev_i,
  input  logic             feat_en_i,
  output logic [XLEN-1:0]  result_o,
  output logic             wr_en_o,
  output logic             illegal_o
);
  logic            sel_bit;
  bool_ctl_t       ctl;
  logic [XLEN-1:0] value;

  assign ctl = '{neg: neg_i, rev: rev_i};

  cr_bit_pick #(.FIELDS(FIELDS), .FIELD_W(FIELD_W)) u_pick (
    .cr_i (cr_i),
    .idx_i(bit_idx_i),
    .bit_o(sel_bit)
  );

  cr_bool_form #(.XLEN(XLEN)) u_form (
    .bit_i  (sel_bit),
    .ctl_i  (ctl),
    .value_o(value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= req_i & feat_en_i;
      illegal_o <= req_i & ~feat_en_i;
      if (req_i) result_o <= feat_en_i ? value : '0;
    end
  end

  AST_WR_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(req_i && feat_en_i)); // R6
  AST_ILL_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(req_i && !feat_en_i)); // R7
  AST_ILL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && illegal_o)); // R7
  AST_ILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0)); // R7
  AST_RES_BOOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((result_o == '0) || (result_o == XLEN'(1)) || (&result_o))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> (!wr_en_o && !illegal_o && $stable(result_o))); // R8
endmodule

// File: tb/sim_cr_bool_set.sv
module sim_cr_bool_set;
  localparam int N = 12;
  // {cr, idx, neg, rev, expected}
  localparam logic [102:0] VEC [N] = '{
    {32'h8000_0000, 5'd0,  1'b0, 1'b0, 64'd1},
    {32'h8000_0000, 5'd1,  1'b0, 1'b0, 64'd0},
    {32'h0000_0001, 5'd31, 1'b0, 1'b0, 64'd1},
    {32'h0000_0001, 5'd30, 1'b0, 1'b0, 64'd0},
    {32'h0100_0000, 5'd7,  1'b0, 1'b0, 64'd1},
    {32'h2000_0000, 5'd2,  1'b0, 1'b0, 64'd1},
    {32'h0000_0010, 5'd27, 1'b0, 1'b1, 64'd0},
    {32'h0000_0000, 5'd12, 1'b0, 1'b1, 64'd1},
    {32'hFFFF_FFFF, 5'd5,  1'b1, 1'b0, {64{1'b1}}},
    {32'hFFFF_FFFF, 5'd5,  1'b1, 1'b1, 64'd0},
    {32'h0000_0000, 5'd20, 1'b1, 1'b1, {64{1'b1}}},
    {32'h0000_0000, 5'd3,  1'b1, 1'b0, 64'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, neg = 1'b0, rev = 1'b0, en = 1'b1;
  logic [31:0] cr = '0;
  logic [4:0] idx = '0;
  logic [63:0] res;
  logic we, ill;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  cr_bool_set u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cr_i(cr), .bit_idx_i(idx),
    .neg_i(neg), .rev_i(rev), .feat_en_i(en),
    .result_o(res), .wr_en_o(we), .illegal_o(ill)
  );

  task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] c, input logic [4:0] i, input logic n,
                       input logic r, input logic e);
    @(negedge clk);
    cr = c; idx = i; neg = n; rev = r; en = e; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    logic [63:0] kept;
    repeat (3) @(negedge clk);
    chk("R1 reset", {res, we, ill}, 66'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res, we, ill}, 66'd0);

    for (int k = 0; k < N; k++) begin
      issue(VEC[k][102:71], VEC[k][70:66], VEC[k][65], VEC[k][64], 1'b1);
      chk($sformatf("R2/R3/R4/R5 vec%0d", k), {res, we, ill}, {VEC[k][63:0], 1'b1, 1'b0});
    end

    // R8: idle cycle holds result, strobes low
    kept = res;
    @(negedge clk);
    chk("R8 idle hold", {res, we, ill}, {kept, 1'b0, 1'b0});

    // R7: disabled feature
    issue(32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, 1'b0);
    chk("R7 illegal", {res, we, ill}, {64'd0, 1'b0, 1'b1});
    @(negedge clk);
    chk("R7 illegal one cycle", {we, ill}, 66'd0);

    // R6: back-to-back requests
    @(negedge clk);
    cr = 32'h0000_0008; idx = 5'd28; neg = 1'b0; rev = 1'b0; en = 1'b1; req = 1'b1;
    @(negedge clk);
    chk("R6 first strobe", {res, we, ill}, {64'd1, 1'b1, 1'b0});
    rev = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R6 second strobe", {res, we, ill}, {64'd0, 1'b1, 1'b0});
    @(negedge clk);
    chk("R6 strobe ends", {res, we, ill}, {64'd0, 1'b0, 1'b0});

    // R1: reset mid-run clears outputs
    issue(32'h8000_0000, 5'd0, 1'b1, 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {res, we, ill}, 66'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule